// File: doc/BRIEF.md
# Scoreboarded Float Register File

This block holds 32 single-precision floating-point registers. Each register keeps its value as three separate fields: a 1-bit sign, an 8-bit exponent and a 23-bit mantissa. A parameter sets the number of read ports and another sets the number of write ports. Reads are combinational. Writes take effect on the rising clock edge.

Next to the storage sits a pending-write scoreboard with one bit per register. An issue stage marks destination registers as pending through a set mask. Any valid write to a register clears that register's bit. If the same bit is set and cleared in one cycle, the set wins.

An exception output flags, in the same cycle, any case where two enabled write ports name the same register. In that case the highest-numbered port's data is stored.

Top module: `fp_regfile`

## Requirements
- R1: While reset is held, and after it is released, every register reads as zero in all three fields, and the scoreboard output is all zeros.
- R2: A read port with its enable high presents the addressed register's sign, exponent and mantissa in the same cycle, with no clock edge in between.
- R3: A read port with its enable low drives zero on its sign, exponent and mantissa outputs, whatever register it addresses.
- R4: A write port with its enable high stores its fields into the addressed register at the next rising edge. The new value is not visible before that edge. A port with its enable low changes no register.
- R5: Several write ports may each store into a different register at the same edge, and every one of those writes lands.
- R6: At each edge, every bit that is 1 in the set mask becomes 1 in the scoreboard. A scoreboard bit never rises unless its mask bit was 1.
- R7: An enabled write to register n clears scoreboard bit n at that edge. Bit n is register n, with bit 0 as the least significant bit.
- R8: Set and clear may happen in one cycle. Starting from 0b11100, writes to registers 2 and 3 together with a mask of 0b00001 give 0b10001. When one bit is both set and cleared, it ends up set.
- R9: The conflict output is high in the same cycle exactly when two or more enabled write ports carry the same address. It stays low when the addresses differ, or when only one of the colliding ports is enabled.
- R10: On a write conflict, the register takes the data of the highest-numbered enabled port that addresses it.
- R11: The 1-bit sign, 8-bit exponent and 23-bit mantissa are stored and returned independently and bit-exactly. Port p uses slice p of each flattened bus, and port 0 is the least significant slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | NRD | Read enable per port |
| rd_idx | input | NRD*5 | Read register index per port |
| rd_sgn | output | NRD | Read sign per port |
| rd_exp | output | NRD*EXP_W | Read exponent per port |
| rd_man | output | NRD*MAN_W | Read mantissa per port |
| wr_en | input | NWR | Write enable per port |
| wr_idx | input | NWR*5 | Write register index per port |
| wr_sgn | input | NWR | Write sign per port |
| wr_exp | input | NWR*EXP_W | Write exponent per port |
| wr_man | input | NWR*MAN_W | Write mantissa per port |
| pend_set | input | NREG | Scoreboard set mask |
| pend | output | NREG | Scoreboard, one bit per register |
| wr_clash | output | 1 | Two enabled write ports share an address |

## Verification
The bench builds the block with two read ports and three write ports. Two read ports let two different registers be checked in one cycle, and let a disabled port be compared with an enabled one. Three write ports make three-way conflicts possible, so the highest-numbered-port rule can be told apart from a rule that only compares the first two ports. The scoreboard cases include the mixed set-and-clear example and the case where the same bit is both set and cleared.

// File: rtl/fp_regfile.sv
module fp_regfile #(
  parameter int NRD   = 2,
  parameter int NWR   = 2,
  parameter int NREG  = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NRD-1:0]       rd_en,
  input  logic [NRD*AW-1:0]    rd_idx,
  output logic [NRD-1:0]       rd_sgn,
  output logic [NRD*EXP_W-1:0] rd_exp,
  output logic [NRD*MAN_W-1:0] rd_man,
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR*AW-1:0]    wr_idx,
  input  logic [NWR-1:0]       wr_sgn,
  input  logic [NWR*EXP_W-1:0] wr_exp,
  input  logic [NWR*MAN_W-1:0] wr_man,
  input  logic [NREG-1:0]      pend_set,
  output logic [NREG-1:0]      pend,
  output logic                 wr_clash
);

  logic [NREG-1:0]  sgn_q;
  logic [EXP_W-1:0] exp_q [NREG];
  logic [MAN_W-1:0] man_q [NREG];
  logic [NREG-1:0]  clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q <= '0;
      for (int r = 0; r < NREG; r++) begin
        exp_q[r] <= '0;
        man_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        for (int p = 0; p < NWR; p++) begin
          if (wr_en[p] && wr_idx[p*AW +: AW] == AW'(r)) begin
            sgn_q[r] <= wr_sgn[p];
            exp_q[r] <= wr_exp[p*EXP_W +: EXP_W];
            man_q[r] <= wr_man[p*MAN_W +: MAN_W];
          end
        end
      end
    end
  end

  always_comb begin
    clr = '0;
    for (int p = 0; p < NWR; p++)
      if (wr_en[p]) clr[wr_idx[p*AW +: AW]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | pend_set;
  end

  always_comb begin
    wr_clash = 1'b0;
    for (int i = 0; i < NWR; i++)
      for (int j = i + 1; j < NWR; j++)
        if (wr_en[i] && wr_en[j] && wr_idx[i*AW +: AW] == wr_idx[j*AW +: AW])
          wr_clash = 1'b1;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    wire [AW-1:0] a = rd_idx[i*AW +: AW];
    assign rd_sgn[i]                 = rd_en[i] & sgn_q[a];
    assign rd_exp[i*EXP_W +: EXP_W]  = rd_en[i] ? exp_q[a] : '0;
    assign rd_man[i*MAN_W +: MAN_W]  = rd_en[i] ? man_q[a] : '0;
  end

endmodule

module fp_regfile_chk #(
  parameter int NRD   = 2,
  parameter int NWR   = 2,
  parameter int NREG  = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int AW   = $clog2(NREG)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NRD-1:0]       rd_en,
  input logic [NRD-1:0]       rd_sgn,
  input logic [NRD*EXP_W-1:0] rd_exp,
  input logic [NRD*MAN_W-1:0] rd_man,
  input logic [NWR-1:0]       wr_en,
  input logic [NWR*AW-1:0]    wr_idx,
  input logic [NREG-1:0]      pend_set,
  input logic [NREG-1:0]      pend,
  input logic                 wr_clash
);

  logic                armed;
  logic [NREG-1:0]     set_d, pend_d;
  logic [NWR-1:0]      wen_d;
  logic [NWR*AW-1:0]   widx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; set_d <= '0; pend_d <= '0; wen_d <= '0; widx_d <= '0;
    end else begin
      armed <= 1'b1; set_d <= pend_set; pend_d <= pend; wen_d <= wr_en; widx_d <= wr_idx;
    end
  end

  // R6
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((pend & set_d) == set_d));

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((pend & ~pend_d & ~set_d) == '0));

  // R9
  single_writer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_en) <= 1) |-> !wr_clash);

  for (genvar p = 0; p < NWR; p++) begin : g_wp
    // R7
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wen_d[p]) |-> (pend[widx_d[p*AW +: AW]] == set_d[widx_d[p*AW +: AW]]));
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rp
    // R3
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[i] |-> (!rd_sgn[i] && rd_exp[i*EXP_W +: EXP_W] == '0 && rd_man[i*MAN_W +: MAN_W] == '0));
  end

endmodule

bind fp_regfile fp_regfile_chk #(
  .NRD(NRD), .NWR(NWR), .NREG(NREG), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sgn(rd_sgn), .rd_exp(rd_exp),
  .rd_man(rd_man), .wr_en(wr_en), .wr_idx(wr_idx), .pend_set(pend_set),
  .pend(pend), .wr_clash(wr_clash)
);

// File: tb/fp_regfile_bench.sv
module fp_regfile_bench;
  localparam int NRD = 2, NWR = 3, NREG = 32, EW = 8, MW = 23, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NRD-1:0] rd_en = '0;  logic [NRD*AW-1:0] rd_idx = '0;
  logic [NRD-1:0] rd_sgn;      logic [NRD*EW-1:0] rd_exp; logic [NRD*MW-1:0] rd_man;
  logic [NWR-1:0] wr_en = '0;  logic [NWR*AW-1:0] wr_idx = '0;
  logic [NWR-1:0] wr_sgn = '0; logic [NWR*EW-1:0] wr_exp = '0; logic [NWR*MW-1:0] wr_man = '0;
  logic [NREG-1:0] pend_set = '0, pend;
  logic wr_clash;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  fp_regfile #(.NRD(NRD), .NWR(NWR), .NREG(NREG), .EXP_W(EW), .MAN_W(MW)) u_fp_regfile (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_sgn(rd_sgn),
    .rd_exp(rd_exp), .rd_man(rd_man), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sgn(wr_sgn),
    .wr_exp(wr_exp), .wr_man(wr_man), .pend_set(pend_set), .pend(pend), .wr_clash(wr_clash));

  always #2.5 clk = ~clk;

  // {addr[4:0], sign, exponent[7:0], mantissa[22:0]}
  localparam logic [36:0] VEC [8] = '{
    {5'd0,  1'b1, 8'h7F, 23'h000001}, {5'd31, 1'b0, 8'hFF, 23'h7FFFFF},
    {5'd5,  1'b1, 8'h00, 23'h400000}, {5'd12, 1'b0, 8'h81, 23'h2AAAAA},
    {5'd17, 1'b1, 8'hFE, 23'h555555}, {5'd1,  1'b0, 8'h01, 23'h000000},
    {5'd30, 1'b1, 8'h80, 23'h123456}, {5'd9,  1'b0, 8'h93, 23'h0F0F0F}};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic rd(int p, logic en, int a);
    rd_en[p] = en; rd_idx[p*AW +: AW] = AW'(a); #1;
  endtask

  function automatic logic [31:0] rval(int p);
    return {rd_sgn[p], rd_exp[p*EW +: EW], rd_man[p*MW +: MW]};
  endfunction

  task automatic wr(int p, logic en, int a, logic [31:0] w);
    wr_en[p] = en; wr_idx[p*AW +: AW] = AW'(a);
    wr_sgn[p] = w[31]; wr_exp[p*EW +: EW] = w[30:23]; wr_man[p*MW +: MW] = w[22:0];
  endtask

  task automatic wr_off(); wr_en = '0; endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_off(); pend_set = '0; #7; rst_n = 1'b1; tick();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2;
    // R1 during reset
    rd(0, 1, 31);
    chk("R1 read during reset", rval(0), 0);
    chk("R1 scoreboard during reset", pend, 0);
    #5; rst_n = 1'b1; tick();
    for (int r = 0; r < NREG; r++) begin
      rd(0, 1, r);
      chk($sformatf("R1 reg %0d after reset", r), rval(0), 0);
    end
    chk("R1 scoreboard after reset", pend, 0);

    // R11 / R4 table walk
    foreach (VEC[k]) begin
      wr(0, 1, VEC[k][36:32], VEC[k][31:0]); tick();
    end
    wr_off();
    foreach (VEC[k]) begin
      rd(0, 1, VEC[k][36:32]); rd(1, 1, VEC[7-k][36:32]);
      chk($sformatf("R11 port0 entry %0d", k), rval(0), VEC[k][31:0]);
      chk($sformatf("R11 port1 entry %0d", 7-k), rval(1), VEC[7-k][31:0]);
    end

    // R2 combinational read
    rd(0, 1, 5);  chk("R2 first addr", rval(0), VEC[2][31:0]);
    rd(0, 1, 12); chk("R2 addr change same cycle", rval(0), VEC[3][31:0]);

    // R3 disabled read port
    rd(1, 0, 31); chk("R3 disabled port zero", rval(1), 0);
    rd(1, 1, 31); chk("R3 re-enabled port", rval(1), VEC[1][31:0]);

    // R4 not visible before edge, disabled write no effect
    wr(0, 1, 5, 32'hC0A0_0001); rd(0, 1, 5);
    chk("R4 before edge", rval(0), VEC[2][31:0]);
    tick(); wr_off(); #1;
    chk("R4 after edge", rval(0), 32'hC0A0_0001);
    wr(1, 0, 5, 32'h1234_5678); tick(); wr_off(); #1;
    chk("R4 disabled write ignored", rval(0), 32'hC0A0_0001);

    // R5 three distinct writes
    wr(0, 1, 2, 32'h1111_1111); wr(1, 1, 3, 32'h2222_2222); wr(2, 1, 4, 32'hA333_3333);
    #1; chk("R9 distinct addrs no clash", wr_clash, 0);
    tick(); wr_off();
    rd(0, 1, 2); rd(1, 1, 3);
    chk("R5 port0 landed", rval(0), 32'h1111_1111);
    chk("R5 port1 landed", rval(1), 32'h2222_2222);
    rd(0, 1, 4); chk("R5 port2 landed", rval(0), 32'hA333_3333);

    // R9 / R10 conflicts
    wr(0, 1, 7, 32'h0000_0AAA); wr(1, 1, 7, 32'h0000_0BBB); wr(2, 1, 7, 32'h8000_0CCC);
    #1; chk("R9 three-way clash", wr_clash, 1);
    tick(); wr_off(); rd(0, 1, 7);
    chk("R10 highest port wins of three", rval(0), 32'h8000_0CCC);
    wr(0, 1, 8, 32'h0000_0111); wr(1, 1, 8, 32'h0000_0222);
    #1; chk("R9 two-way clash", wr_clash, 1);
    tick(); wr_off(); rd(0, 1, 8);
    chk("R10 port1 over port0", rval(0), 32'h0000_0222);
    wr(0, 1, 9, 32'h0); wr(2, 1, 9, 32'h0); wr_en[2] = 1'b0;
    #1; chk("R9 one colliding port disabled", wr_clash, 0);
    wr(0, 1, 10, 32'h0); wr(2, 1, 10, 32'h0);
    #1; chk("R9 ports 0 and 2 clash", wr_clash, 1);
    wr_off(); #1; chk("R9 clash drops", wr_clash, 0);

    // Scoreboard
    do_reset();
    pend_set = 32'h1F; #1;
    chk("R6 not set before edge", pend, 0);
    tick(); pend_set = '0;
    chk("R6 mask ORed in", pend, 32'h1F);
    wr(0, 1, 0, 32'h0); wr(1, 1, 1, 32'h0); tick(); wr_off();
    chk("R7 writes clear bits 0 and 1", pend, 32'h1C);
    pend_set = 32'h1; wr(0, 1, 2, 32'h0); wr(2, 1, 3, 32'h0); tick(); wr_off(); pend_set = '0;
    chk("R8 mixed set and clear", pend, 32'h11);
    pend_set = 32'h40; wr(1, 1, 6, 32'h0); tick(); wr_off(); pend_set = '0;
    chk("R8 set wins on same bit", pend, 32'h51);
    pend_set = 32'h8000_0000; wr(0, 0, 4, 32'h0); tick(); pend_set = '0;
    chk("R6 bit 31 set, disabled write clears nothing", pend, 32'h8000_0051);
    tick();
    chk("R6 scoreboard holds with no activity", pend, 32'h8000_0051);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule